// File: doc/BRIEF.md
# Two-Level Random-Discard Admission Controller

This block sits in front of one output queue of a packet switch. It decides whether each frame offered to that queue is admitted or discarded. It keeps a count of the frame buffers the queue holds. Each offered frame is judged against that count, the frame's drop class and a pseudo-random number.

The count has two occupancy thresholds. Above the lower one, high-drop frames start to be discarded at random. Above the upper one, both classes are discarded at random, and high-drop frames more often than low-drop frames. A programmable number of buffers near the top is kept for low-drop frames, and a completely full queue refuses everything.

The block only acts while link-level flow control is off. With flow control on, every frame is admitted. On a half-duplex link the class-based rules are off unless a separate enable is set.

Top module: `wred_admit`

## Requirements
- R1: After reset `occ` is 0 and both `accept` and `drop` are low.
- R2: `occ` rises by 1 on a cycle with `alloc` alone and falls by 1 on a cycle with `free` alone. It does not change when both are high in the same cycle. It saturates at 0 and at MAX_BUF.
- R3: The cycle after `req` is sampled high, exactly one of `accept` and `drop` is high. Both are low the cycle after `req` is low. The decision uses `occ` as it was before that cycle's update.
- R4: While `occ` is below THR_LO and the frame is not refused by R8 or R9, the frame is accepted.
- R5: The random draw `r` is bits [1:0] of a 16-bit shift register. The register resets to 16'hACE1 and shifts left once per `req`, with the new bit 0 equal to bit15 ^ bit13 ^ bit12 ^ bit10. Each decision uses the value held before its own shift.
- R6: With THR_LO <= `occ` < THR_HI, a high-drop frame (`drop_hi`=1) is dropped exactly when r < 2, which is a 50% chance. A low-drop frame (`drop_hi`=0) is never dropped by the random rule in this band.
- R7: With `occ` >= THR_HI, a high-drop frame is dropped exactly when r < 3 (75%), and a low-drop frame exactly when r < 1 (25%).
- R8: A high-drop frame is dropped when MAX_BUF - `occ` <= `rsv_bufs`, whatever the value of r.
- R9: Any frame is dropped when `occ` equals MAX_BUF and flow control is off.
- R10: With `fc_en` high, every offered frame is accepted.
- R11: With `half_duplex` high and `hd_qos_en` low, only R9 can drop a frame. With `hd_qos_en` high, the rules in R6, R7 and R8 apply as on a full-duplex link.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fc_en | input | 1 | Link-level flow control is on; the block admits everything |
| half_duplex | input | 1 | The link runs half duplex |
| hd_qos_en | input | 1 | Turns the class-based rules on for half-duplex links |
| rsv_bufs | input | CNT_W | Number of buffers kept for low-drop frames |
| alloc | input | 1 | One buffer is taken by the queue |
| free | input | 1 | One buffer is returned by the queue |
| req | input | 1 | A frame is offered |
| drop_hi | input | 1 | Drop class of the offered frame: 1 high-drop, 0 low-drop |
| accept | output | 1 | The frame offered last cycle is admitted |
| drop | output | 1 | The frame offered last cycle is discarded |
| occ | output | CNT_W | Current buffer occupancy |

## Verification
The bench uses the default parameters: MAX_BUF of 96, thresholds at 72 and 84, and an 8-bit count. With these values a few hundred allocate pulses reach both bands and both saturation limits. The bench fills the queue step by step and offers runs of frames of both classes in each band. At each frame its own shift-register model predicts whether the draw falls under the band's quarter limit. It then sets the reserve to 8 so that the reserved region overlaps the upper band, which separates the reserve refusal from the random rule.

// File: rtl/wred_admit.sv
module wred_admit #(
  parameter int CNT_W   = 8,
  parameter int MAX_BUF = 96,
  parameter int THR_LO  = 72,
  parameter int THR_HI  = 84,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fc_en,
  input  logic             half_duplex,
  input  logic             hd_qos_en,
  input  logic [CNT_W-1:0] rsv_bufs,
  input  logic             alloc,
  input  logic             free,
  input  logic             req,
  input  logic             drop_hi,
  output logic             accept,
  output logic             drop,
  output logic [CNT_W-1:0] occ
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_BUF);
  localparam logic [CNT_W-1:0] LOC  = CNT_W'(THR_LO);
  localparam logic [CNT_W-1:0] HIC  = CNT_W'(THR_HI);

  logic [15:0] lfsr;
  logic [1:0]  quarters;

  wire full     = (occ == MAXC);
  wire qos_on   = !half_duplex || hd_qos_en;
  wire rsv_hit  = drop_hi && ((MAXC - occ) <= rsv_bufs);
  wire wred_hit = lfsr[1:0] < quarters;
  wire refuse   = !fc_en && (full || (qos_on && (rsv_hit || wred_hit)));
  wire inc      = alloc && !free && !full;
  wire dec      = free && !alloc && (occ != '0);

  always_comb begin
    if (occ >= HIC)      quarters = drop_hi ? 2'd3 : 2'd1;
    else if (occ >= LOC) quarters = drop_hi ? 2'd2 : 2'd0;
    else                 quarters = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ    <= '0;
      lfsr   <= SEED;
      accept <= 1'b0;
      drop   <= 1'b0;
    end else begin
      if (inc)      occ <= occ + 1'b1;
      else if (dec) occ <= occ - 1'b1;
      accept <= req && !refuse;
      drop   <= req && refuse;
      if (req) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
  end
endmodule

// File: rtl/wred_admit_chk.sv
module wred_admit_chk #(
  parameter int CNT_W   = 8,
  parameter int MAX_BUF = 96,
  parameter int THR_HI  = 84
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fc_en,
  input logic             alloc,
  input logic             free,
  input logic             req,
  input logic             drop_hi,
  input logic             accept,
  input logic             drop,
  input logic [CNT_W-1:0] occ
);
  localparam logic [CNT_W-1:0] MAXC = CNT_W'(MAX_BUF);
  localparam logic [CNT_W-1:0] HIC  = CNT_W'(THR_HI);

  // R3
  excl_out_chk: assert property (@(posedge clk) disable iff (!rst_n) !(accept && drop));
  // R3
  one_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n) req |=> (accept ^ drop));
  // R3
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !req |=> (!accept && !drop));
  // R10
  fc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n) (req && fc_en) |=> accept);
  // R2
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (alloc && free) |=> occ == $past(occ));
  // R2
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n) occ <= MAXC);
  // R6
  low_mid_chk: assert property (@(posedge clk) disable iff (!rst_n) (req && !drop_hi && occ < HIC) |=> accept);
endmodule

bind wred_admit wred_admit_chk #(.CNT_W(CNT_W), .MAX_BUF(MAX_BUF), .THR_HI(THR_HI)) chk_i (
  .clk(clk), .rst_n(rst_n), .fc_en(fc_en), .alloc(alloc), .free(free),
  .req(req), .drop_hi(drop_hi), .accept(accept), .drop(drop), .occ(occ));

// File: tb/wred_admit_tb.sv
`timescale 1ns/1ps
module wred_admit_tb_top;
  localparam int MAXB = 96;
  localparam int TLO  = 72;
  localparam int THI  = 84;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fc_en = 0, half_duplex = 0, hd_qos_en = 0;
  logic [7:0] rsv_bufs = 8'd0;
  logic alloc = 0, free = 0, req = 0, drop_hi = 0;
  logic accept, drop;
  logic [7:0] occ;

  int vectors = 0, errors = 0;
  int occ_m = 0;
  int lfsr_m = 16'hACE1;

  always #4 clk = ~clk;

  wred_admit dut_i (.clk(clk), .rst_n(rst_n), .fc_en(fc_en), .half_duplex(half_duplex),
    .hd_qos_en(hd_qos_en), .rsv_bufs(rsv_bufs), .alloc(alloc), .free(free), .req(req),
    .drop_hi(drop_hi), .accept(accept), .drop(drop), .occ(occ));

  task automatic cmp(input int act_a, act_d, act_o, exp_a, exp_d, exp_o, input string tag);
    vectors++;
    if (act_a != exp_a || act_d != exp_d || act_o != exp_o) begin
      errors++;
      $display("FAIL %s: acc/drp/occ actual %0d/%0d/%0d expected %0d/%0d/%0d",
               tag, act_a, act_d, act_o, exp_a, exp_d, exp_o);
    end
  endtask

  task automatic step(input logic a, f, r, h, input string tag);
    int ea, ed, q, rnd;
    bit refuse, qos;
    alloc = a; free = f; req = r; drop_hi = h;
    @(posedge clk);
    ea = 0; ed = 0;
    if (r) begin
      rnd = lfsr_m & 3;
      if (occ_m >= THI) q = h ? 3 : 1;
      else if (occ_m >= TLO) q = h ? 2 : 0;
      else q = 0;
      qos = !half_duplex || hd_qos_en;
      refuse = !fc_en && (occ_m == MAXB ||
               (qos && ((h && (MAXB - occ_m) <= rsv_bufs) || rnd < q)));
      ea = refuse ? 0 : 1;
      ed = refuse ? 1 : 0;
      lfsr_m = ((lfsr_m << 1) | (((lfsr_m >> 15) ^ (lfsr_m >> 13) ^ (lfsr_m >> 12) ^ (lfsr_m >> 10)) & 1)) & 16'hFFFF;
    end
    if (a && !f && occ_m < MAXB) occ_m++;
    else if (f && !a && occ_m > 0) occ_m--;
    #1;
    cmp(accept, drop, occ, ea, ed, occ_m, tag);
    @(negedge clk);
    alloc = 0; free = 0; req = 0;
  endtask

  task automatic fill_to(input int n);
    while (occ_m < n) step(1, 0, 0, 0, "R2");
    while (occ_m > n) step(0, 1, 0, 0, "R2");
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #20;
    cmp(accept, drop, occ, 0, 0, 0, "R1");
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    cmp(accept, drop, occ, 0, 0, 0, "R1");
    // R2 underflow, simultaneous, basic counting
    step(0, 1, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");
    step(1, 1, 0, 0, "R2");
    step(1, 0, 0, 0, "R2");
    step(0, 1, 0, 0, "R2");
    // R3 R4 R5 below lower threshold, request with counter activity
    for (int i = 0; i < 12; i++) step(i % 2, 0, 1, i[1], "R4");
    step(0, 0, 0, 0, "R3");
    fill_to(TLO);
    for (int i = 0; i < 24; i++) step(0, 0, 1, i[0] | i[2], "R6");
    fill_to(THI - 1);
    for (int i = 0; i < 16; i++) step(0, 0, 1, i[0], "R6");
    fill_to(THI);
    for (int i = 0; i < 32; i++) step(0, 0, 1, i[0] ^ i[3], "R7");
    step(1, 0, 1, 1, "R5");
    step(0, 1, 1, 0, "R5");
    // R8 reserve overlaps the upper band
    rsv_bufs = 8'd8;
    fill_to(MAXB - 8);
    for (int i = 0; i < 12; i++) step(0, 0, 1, i[0], "R8");
    fill_to(MAXB - 9);
    for (int i = 0; i < 12; i++) step(0, 0, 1, i[0], "R8");
    rsv_bufs = 8'd0;
    // R9 full queue and saturation at the top
    fill_to(MAXB);
    step(1, 0, 0, 0, "R2");
    for (int i = 0; i < 6; i++) step(0, 0, 1, i[0], "R9");
    // R10 flow control on
    fc_en = 1;
    for (int i = 0; i < 6; i++) step(0, 0, 1, i[0], "R10");
    fc_en = 0;
    // R11 half duplex
    rsv_bufs = 8'd8;
    fill_to(MAXB - 4);
    half_duplex = 1;
    for (int i = 0; i < 10; i++) step(0, 0, 1, i[0], "R11");
    hd_qos_en = 1;
    for (int i = 0; i < 10; i++) step(0, 0, 1, i[0], "R11");
    hd_qos_en = 0;
    fill_to(MAXB);
    for (int i = 0; i < 4; i++) step(0, 0, 1, i[0], "R11");
    half_duplex = 0;
    fill_to(0);
    step(0, 1, 1, 1, "R2");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule